// File: doc/BRIEF.md
# Fully Associative Address Translator with Access Checks

This block turns a 32-bit virtual address into a physical address for one request at a time. It holds a parameterised number of translation entries. Each entry has a page number, a frame number, an address-space tag, a 2-bit page size, and valid, global, two permission and modified flags. Before any entry is looked at, the address is checked against fixed windows that skip translation. A global enable can also turn translation off, so that the address is just truncated. When a lookup runs, every entry is compared at once. The single entry that matches then supplies the frame, and its permission and modified bits decide whether the access is allowed. The block reports either a physical address or a fault code taken from the processor's exception numbering.

A request is taken in any cycle in which `req_i` is high. The result appears on the outputs one clock later, together with a one-cycle `rsp_valid_o`. Entries are loaded through a plain index/data write port. A write takes effect at the clock edge that performs it, so a request in the same cycle still sees the old contents. The control is a two-state machine. `ST_IDLE` waits for a request. `ST_RESP` presents a result. The transitions are `IDLE_TO_RESP` on a request, `RESP_TO_RESP` on a request that follows directly, and `RESP_TO_IDLE` when no request follows.

Top module: `tlb_xlate`

## Requirements
- R1: After reset `rsp_valid_o`, `hit_o`, `fault_o` and `paddr_o` are all zero, and every entry is invalid.
- R2: A request sampled at a clock edge gives `rsp_valid_o`=1 for exactly the following cycle, with the result on `paddr_o`/`hit_o`/`fault_o`. `rsp_valid_o` is 0 after a cycle with no request.
- R3: When `wr_en_i` is high, the entry at `wr_idx_i` is replaced by the write fields at the clock edge. Requests from the next cycle on see the new contents.
- R4: An entry takes part in a match only if its valid flag is set. The tag comparison is skipped when the entry's global flag is set, or when `single_tag_i` and `priv_i` are both 1. Otherwise `wr_tag_i` must equal `tag_i`.
- R5: `wr_size_i` encodes the page size: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB, 3 is 1 MB. The page base is the page number shifted left by 10 and cleared below the page size. The physical address is the frame number shifted left by 10, cleared the same way, ORed with the in-page offset of the virtual address.
- R6: If two or more entries match, `fault_o`=0x140 and `hit_o`=0.
- R7: If no entry matches, `fault_o` is 0x060 for a store (`acc_i`=2) and 0x040 for a fetch (`acc_i`=0) or load (`acc_i`=1 or 3).
- R8: With `priv_i`=0, a matching entry whose permission bit 1 is clear gives 0x0C0 for a store and 0x0A0 otherwise.
- R9: A store that passes R8 gives 0x0C0 if permission bit 0 is clear. Otherwise it gives 0x080 if the modified flag is clear. Write permission is checked before the modified flag.
- R10: Addresses 0x80000000–0xBFFFFFFF skip translation with bits 31:29 cleared. Addresses at or above 0xE0000000 skip it unchanged. `hit_o`=0 in both cases, even with translation enabled.
- R11: With `priv_i`=0, an access to an R10 region outside 0xE0000000–0xE3FFFFFF gives 0x100 for a store and 0x0E0 otherwise.
- R12: With `xlate_en_i`=0, any address outside the R10 regions maps to its low 29 bits, with `hit_o`=0 and no fault.
- R13: Whenever `fault_o`≠0, `paddr_o` is 0. `hit_o` is 1 exactly when a lookup found one matching entry, including when the access then faults on permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write one entry |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_vpn_i | input | 22 | Virtual page number (address bits 31:10) |
| wr_ppn_i | input | 19 | Physical frame number (address bits 28:10) |
| wr_tag_i | input | 8 | Address-space tag |
| wr_size_i | input | 2 | Page size code |
| wr_valid_i | input | 1 | Entry valid |
| wr_global_i | input | 1 | Skip the tag comparison for this entry |
| wr_perm_i | input | 2 | Bit 1: user access allowed; bit 0: writes allowed |
| wr_dirty_i | input | 1 | Page already modified |
| req_i | input | 1 | Lookup request strobe |
| vaddr_i | input | 32 | Virtual address |
| acc_i | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| priv_i | input | 1 | Privileged mode |
| tag_i | input | 8 | Current address-space tag |
| xlate_en_i | input | 1 | Translation enable |
| single_tag_i | input | 1 | Privileged accesses ignore tags |
| rsp_valid_o | output | 1 | Result valid |
| paddr_o | output | 32 | Physical address (0 on fault) |
| hit_o | output | 1 | Exactly one entry matched |
| fault_o | output | 12 | Fault code, 0 when none |

## Verification
The assertions check the response timing of R2 on every cycle. They also check that a faulting result always carries a zero address, that a multiple match never shows a hit, that privileged requests never get the region-denied codes, and that a hit only ever comes with no fault or a permission fault. Only the directed scenarios can show the address arithmetic of each page size, the tag and global rules, the exact fault chosen when several checks fail, and the boundaries of the bypass windows, because these need values computed from known entry contents.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

    localparam int VA_W   = 32;
    localparam int VPN_W  = 22;
    localparam int PPN_W  = 19;
    localparam int TAG_W  = 8;
    localparam int CODE_W = 12;

    localparam logic [CODE_W-1:0] FLT_NONE      = 12'h000;
    localparam logic [CODE_W-1:0] FLT_MISS_RD   = 12'h040;
    localparam logic [CODE_W-1:0] FLT_MISS_WR   = 12'h060;
    localparam logic [CODE_W-1:0] FLT_CLEAN_WR  = 12'h080;
    localparam logic [CODE_W-1:0] FLT_PROT_RD   = 12'h0A0;
    localparam logic [CODE_W-1:0] FLT_PROT_WR   = 12'h0C0;
    localparam logic [CODE_W-1:0] FLT_REGION_RD = 12'h0E0;
    localparam logic [CODE_W-1:0] FLT_REGION_WR = 12'h100;
    localparam logic [CODE_W-1:0] FLT_MULTI     = 12'h140;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_LOAD2 = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic             valid;
        logic             global_pg;
        logic [1:0]       perm;
        logic             dirty;
        logic [1:0]       size;
        logic [TAG_W-1:0] tag;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } xlate_entry_t;

    // Page-number bits that take part in comparison for each size code.
    function automatic logic [VPN_W-1:0] size_keep_mask(input logic [1:0] sz);
        logic [VPN_W-1:0] m;
        unique case (sz)
            2'd0:    m = {VPN_W{1'b1}};
            2'd1:    m = {{(VPN_W-2){1'b1}}, 2'b0};
            2'd2:    m = {{(VPN_W-6){1'b1}}, 6'b0};
            default: m = {{(VPN_W-10){1'b1}}, 10'b0};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tlb_entry_bank.sv
module tlb_entry_bank
    import tlb_xlate_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  xlate_entry_t wr_entry_i,
    output xlate_entry_t entries_o [NUM_ENTRIES]
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        xlate_entry_t slot_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                slot_q <= '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                slot_q <= wr_entry_i;
            end
        end
        assign entries_o[g] = slot_q;
    end

endmodule

// File: rtl/tlb_match_unit.sv
module tlb_match_unit
    import tlb_xlate_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  xlate_entry_t     entries_i [NUM_ENTRIES],
    input  logic [VPN_W-1:0] page_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             tag_skip_i,
    output logic             any_o,
    output logic             multi_o,
    output logic [PPN_W-1:0] sel_ppn_o,
    output logic [1:0]       sel_perm_o,
    output logic             sel_dirty_o,
    output logic [1:0]       sel_size_o
);

    logic [NUM_ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        logic tag_ok;
        logic page_ok;
        assign tag_ok  = entries_i[g].global_pg || tag_skip_i ||
                         (entries_i[g].tag == tag_i);
        assign page_ok = ((page_i ^ entries_i[g].vpn) &
                          size_keep_mask(entries_i[g].size)) == '0;
        assign hit_vec[g] = entries_i[g].valid && tag_ok && page_ok;
    end

    always_comb begin
        any_o       = 1'b0;
        multi_o     = 1'b0;
        sel_ppn_o   = '0;
        sel_perm_o  = '0;
        sel_dirty_o = 1'b0;
        sel_size_o  = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (hit_vec[i]) begin
                multi_o     = multi_o | any_o;
                any_o       = 1'b1;
                sel_ppn_o   = sel_ppn_o   | entries_i[i].ppn;
                sel_perm_o  = sel_perm_o  | entries_i[i].perm;
                sel_dirty_o = sel_dirty_o | entries_i[i].dirty;
                sel_size_o  = sel_size_o  | entries_i[i].size;
            end
        end
    end

endmodule

// File: rtl/tlb_region_class.sv
module tlb_region_class
    import tlb_xlate_pkg::*;
(
    input  logic [VA_W-1:0] vaddr_i,
    input  logic            priv_i,
    output logic            bypass_o,
    output logic            denied_o,
    output logic [VA_W-1:0] direct_pa_o
);

    logic low_window;
    logic high_window;
    logic user_window;

    assign low_window  = (vaddr_i[31:30] == 2'b10);
    assign high_window = (vaddr_i[31:29] == 3'b111);
    assign user_window = (vaddr_i[31:26] == 6'b111000);

    assign bypass_o    = low_window || high_window;
    assign denied_o    = bypass_o && !priv_i && !user_window;
    assign direct_pa_o = low_window ? {3'b000, vaddr_i[28:0]} : vaddr_i;

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_xlate_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [21:0]       wr_vpn_i,
    input  logic [18:0]       wr_ppn_i,
    input  logic [7:0]        wr_tag_i,
    input  logic [1:0]        wr_size_i,
    input  logic              wr_valid_i,
    input  logic              wr_global_i,
    input  logic [1:0]        wr_perm_i,
    input  logic              wr_dirty_i,
    input  logic              req_i,
    input  logic [31:0]       vaddr_i,
    input  logic [1:0]        acc_i,
    input  logic              priv_i,
    input  logic [7:0]        tag_i,
    input  logic              xlate_en_i,
    input  logic              single_tag_i,
    output logic              rsp_valid_o,
    output logic [31:0]       paddr_o,
    output logic              hit_o,
    output logic [11:0]       fault_o
);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } xl_state_e;

    xl_state_e state_q, state_d;

    xlate_entry_t wr_entry;
    xlate_entry_t entries [NUM_ENTRIES];

    assign wr_entry = '{valid:     wr_valid_i,
                        global_pg: wr_global_i,
                        perm:      wr_perm_i,
                        dirty:     wr_dirty_i,
                        size:      wr_size_i,
                        tag:       wr_tag_i,
                        vpn:       wr_vpn_i,
                        ppn:       wr_ppn_i};

    tlb_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES)) bank_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_idx_i   (wr_idx_i),
        .wr_entry_i (wr_entry),
        .entries_o  (entries)
    );

    logic             any_m, multi_m, sel_dirty;
    logic [PPN_W-1:0] sel_ppn;
    logic [1:0]       sel_perm, sel_size;

    tlb_match_unit #(.NUM_ENTRIES(NUM_ENTRIES)) match_i (
        .entries_i   (entries),
        .page_i      (vaddr_i[31:10]),
        .tag_i       (tag_i),
        .tag_skip_i  (single_tag_i && priv_i),
        .any_o       (any_m),
        .multi_o     (multi_m),
        .sel_ppn_o   (sel_ppn),
        .sel_perm_o  (sel_perm),
        .sel_dirty_o (sel_dirty),
        .sel_size_o  (sel_size)
    );

    logic            is_bypass, is_denied;
    logic [VA_W-1:0] direct_pa;

    tlb_region_class region_i (
        .vaddr_i     (vaddr_i),
        .priv_i      (priv_i),
        .bypass_o    (is_bypass),
        .denied_o    (is_denied),
        .direct_pa_o (direct_pa)
    );

    // Combinational outcome of the presented request.
    logic              is_store;
    logic [VPN_W-1:0]  keep_m;
    logic [VA_W-1:0]   mapped_pa;
    logic [VA_W-1:0]   res_pa;
    logic              res_hit;
    logic [CODE_W-1:0] res_code;

    assign is_store  = (acc_kind_e'(acc_i) == ACC_STORE);
    assign keep_m    = size_keep_mask(sel_size);
    assign mapped_pa = {3'b000, sel_ppn & keep_m[PPN_W-1:0], 10'b0} |
                       (vaddr_i & ~{keep_m, 10'b0});

    always_comb begin
        res_pa   = '0;
        res_hit  = 1'b0;
        res_code = FLT_NONE;
        if (is_bypass) begin
            if (is_denied) res_code = is_store ? FLT_REGION_WR : FLT_REGION_RD;
            else           res_pa   = direct_pa;
        end else if (!xlate_en_i) begin
            res_pa = {3'b000, vaddr_i[28:0]};
        end else if (multi_m) begin
            res_code = FLT_MULTI;
        end else if (!any_m) begin
            res_code = is_store ? FLT_MISS_WR : FLT_MISS_RD;
        end else begin
            res_hit = 1'b1;
            if (!priv_i && !sel_perm[1])      res_code = is_store ? FLT_PROT_WR : FLT_PROT_RD;
            else if (is_store && !sel_perm[0]) res_code = FLT_PROT_WR;
            else if (is_store && !sel_dirty)   res_code = FLT_CLEAN_WR;
            else                               res_pa   = mapped_pa;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i)  state_d = ST_RESP;   // IDLE_TO_RESP
            ST_RESP: if (!req_i) state_d = ST_IDLE;   // RESP_TO_IDLE, else RESP_TO_RESP
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            paddr_o <= '0;
            hit_o   <= 1'b0;
            fault_o <= '0;
        end else if (req_i) begin
            paddr_o <= res_pa;
            hit_o   <= res_hit;
            fault_o <= res_code;
        end
    end

    assign rsp_valid_o = (state_q == ST_RESP);

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        req_i,
    input logic        priv_i,
    input logic        rsp_valid_o,
    input logic [31:0] paddr_o,
    input logic        hit_o,
    input logic [11:0] fault_o
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> rsp_valid_o);

    // R2
    rsp_only_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !rsp_valid_o);

    // R13
    fault_zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && fault_o != 12'h000) |-> (paddr_o == 32'h0));

    // R6
    multi_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && fault_o == 12'h140) |-> !hit_o);

    // R11
    priv_no_region_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && priv_i) |=> (fault_o != 12'h0E0 && fault_o != 12'h100));

    // R13
    hit_fault_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && hit_o) |->
            (fault_o == 12'h000 || fault_o == 12'h0A0 ||
             fault_o == 12'h0C0 || fault_o == 12'h080));

endmodule

bind tlb_xlate tlb_xlate_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .priv_i      (priv_i),
    .rsp_valid_o (rsp_valid_o),
    .paddr_o     (paddr_o),
    .hit_o       (hit_o),
    .fault_o     (fault_o)
);

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb_top;

    localparam int NE = 8;
    localparam int IW = $clog2(NE);

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic wr_en_i = 1'b0;
    logic [IW-1:0] wr_idx_i = '0;
    logic [21:0] wr_vpn_i = '0;
    logic [18:0] wr_ppn_i = '0;
    logic [7:0]  wr_tag_i = '0;
    logic [1:0]  wr_size_i = '0;
    logic wr_valid_i = 1'b0, wr_global_i = 1'b0, wr_dirty_i = 1'b0;
    logic [1:0]  wr_perm_i = '0;
    logic req_i = 1'b0;
    logic [31:0] vaddr_i = '0;
    logic [1:0]  acc_i = '0;
    logic priv_i = 1'b0;
    logic [7:0]  tag_i = '0;
    logic xlate_en_i = 1'b0, single_tag_i = 1'b0;
    logic rsp_valid_o;
    logic [31:0] paddr_o;
    logic hit_o;
    logic [11:0] fault_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk_i = ~clk_i;

    tlb_xlate #(.NUM_ENTRIES(NE)) dut_i (.*);

    task automatic check(input string req, input logic [31:0] pa,
                         input logic hit, input logic [11:0] code);
        n_cmp++;
        if (!rsp_valid_o || paddr_o !== pa || hit_o !== hit || fault_o !== code) begin
            n_bad++;
            $display("FAIL %s: got v=%0b pa=%h hit=%0b code=%h, exp v=1 pa=%h hit=%0b code=%h",
                     req, rsp_valid_o, paddr_o, hit_o, fault_o, pa, hit, code);
        end
    endtask

    task automatic put_entry(input int idx, input logic [21:0] vpn, input logic [18:0] ppn,
                             input logic [7:0] tg, input logic [1:0] sz, input logic v,
                             input logic gl, input logic [1:0] pm, input logic d);
        wr_en_i = 1'b1; wr_idx_i = IW'(idx); wr_vpn_i = vpn; wr_ppn_i = ppn;
        wr_tag_i = tg; wr_size_i = sz; wr_valid_i = v; wr_global_i = gl;
        wr_perm_i = pm; wr_dirty_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input logic pv,
                          input logic [7:0] tg, input logic xe, input logic st);
        vaddr_i = va; acc_i = acc; priv_i = pv; tag_i = tg; xlate_en_i = xe; single_tag_i = st;
        req_i = 1'b1;
        @(negedge clk_i);
        req_i = 1'b0;
    endtask

    task automatic t_reset();
        n_cmp++;
        if (rsp_valid_o !== 1'b0 || paddr_o !== 32'h0 || hit_o !== 1'b0 || fault_o !== 12'h0) begin
            n_bad++;
            $display("FAIL R1: got v=%0b pa=%h hit=%0b code=%h, exp all zero",
                     rsp_valid_o, paddr_o, hit_o, fault_o);
        end
        lookup(32'h0040_0000, 2'd1, 1'b1, 8'd0, 1'b1, 1'b0);
        check("R1 empty array misses", 32'h0, 1'b0, 12'h040);
    endtask

    task automatic t_basic();
        put_entry(0, 22'h01000, 19'h02000, 8'd5, 2'd1, 1, 0, 2'b11, 1);
        lookup(32'h0040_0ABC, 2'd1, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R3 R5 4K load", 32'h0080_0ABC, 1'b1, 12'h000);
        n_cmp++;
        @(negedge clk_i);
        if (rsp_valid_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R2: got v=%0b exp v=0", rsp_valid_o);
        end
        lookup(32'h0040_0ABC, 2'd1, 1'b0, 8'd6, 1'b1, 1'b0);
        check("R4 R7 tag mismatch load", 32'h0, 1'b0, 12'h040);
        lookup(32'h0040_0ABC, 2'd2, 1'b0, 8'd6, 1'b1, 1'b0);
        check("R7 tag mismatch store", 32'h0, 1'b0, 12'h060);
        lookup(32'h0040_0ABC, 2'd0, 1'b1, 8'd6, 1'b1, 1'b1);
        check("R4 single-tag privileged", 32'h0080_0ABC, 1'b1, 12'h000);
        lookup(32'h0040_0ABC, 2'd0, 1'b0, 8'd6, 1'b1, 1'b1);
        check("R4 single-tag user", 32'h0, 1'b0, 12'h040);
    endtask

    task automatic t_sizes();
        put_entry(1, 22'h040FF, 19'h01CFF, 8'd9, 2'd3, 1, 1, 2'b11, 1);
        lookup(32'h010A_BCDE, 2'd1, 1'b0, 8'd3, 1'b1, 1'b0);
        check("R4 R5 1M global", 32'h007A_BCDE, 1'b1, 12'h000);
        put_entry(2, 22'h08001, 19'h00003, 8'd5, 2'd0, 1, 0, 2'b11, 1);
        lookup(32'h0200_07FF, 2'd1, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R5 1K top offset", 32'h0000_0FFF, 1'b1, 12'h000);
        lookup(32'h0200_0800, 2'd1, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R5 1K next page", 32'h0, 1'b0, 12'h040);
        put_entry(3, 22'h0C000, 19'h00140, 8'd5, 2'd2, 1, 0, 2'b01, 1);
        lookup(32'h0300_1234, 2'd1, 1'b1, 8'd5, 1'b1, 1'b0);
        check("R5 64K privileged", 32'h0005_1234, 1'b1, 12'h000);
    endtask

    task automatic t_perm();
        lookup(32'h0300_1234, 2'd1, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R8 user load", 32'h0, 1'b1, 12'h0A0);
        lookup(32'h0300_1234, 2'd0, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R8 user fetch", 32'h0, 1'b1, 12'h0A0);
        lookup(32'h0300_1234, 2'd2, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R8 user store", 32'h0, 1'b1, 12'h0C0);
        put_entry(4, 22'h10000, 19'h00200, 8'd5, 2'd1, 1, 0, 2'b10, 0);
        lookup(32'h0400_0010, 2'd2, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R9 write-protect before clean", 32'h0, 1'b1, 12'h0C0);
        put_entry(5, 22'h14000, 19'h00100, 8'd5, 2'd1, 1, 0, 2'b11, 0);
        lookup(32'h0500_0020, 2'd2, 1'b1, 8'd5, 1'b1, 1'b0);
        check("R9 clean store", 32'h0, 1'b1, 12'h080);
        lookup(32'h0500_0020, 2'd1, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R9 clean load ok", 32'h0004_0020, 1'b1, 12'h000);
    endtask

    task automatic t_multi();
        put_entry(6, 22'h01000, 19'h00777, 8'd0, 2'd0, 1, 1, 2'b11, 1);
        lookup(32'h0040_0100, 2'd1, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R6 double match", 32'h0, 1'b0, 12'h140);
        lookup(32'h0040_0800, 2'd1, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R5 outside small page", 32'h0080_0800, 1'b1, 12'h000);
        put_entry(6, 22'h01000, 19'h00777, 8'd0, 2'd0, 0, 1, 2'b11, 1);
        lookup(32'h0040_0100, 2'd1, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R3 R4 invalidated entry", 32'h0080_0100, 1'b1, 12'h000);
    endtask

    task automatic t_regions();
        lookup(32'h8123_4567, 2'd1, 1'b1, 8'd5, 1'b1, 1'b0);
        check("R10 low window", 32'h0123_4567, 1'b0, 12'h000);
        lookup(32'hA123_4567, 2'd2, 1'b1, 8'd5, 1'b1, 1'b0);
        check("R10 second window", 32'h0123_4567, 1'b0, 12'h000);
        lookup(32'hE500_0000, 2'd0, 1'b1, 8'd5, 1'b1, 1'b0);
        check("R10 top unchanged", 32'hE500_0000, 1'b0, 12'h000);
        lookup(32'hE3FF_FFF0, 2'd2, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R11 user window ok", 32'hE3FF_FFF0, 1'b0, 12'h000);
        lookup(32'h8000_0000, 2'd1, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R11 user load denied", 32'h0, 1'b0, 12'h0E0);
        lookup(32'hBFFF_FFFF, 2'd2, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R11 user store denied", 32'h0, 1'b0, 12'h100);
        lookup(32'hE400_0000, 2'd0, 1'b0, 8'd5, 1'b1, 1'b0);
        check("R11 user fetch past window", 32'h0, 1'b0, 12'h0E0);
    endtask

    task automatic t_disabled();
        lookup(32'hC123_4567, 2'd2, 1'b0, 8'd5, 1'b0, 1'b0);
        check("R12 disabled high area", 32'h0123_4567, 1'b0, 12'h000);
        lookup(32'h0040_0ABC, 2'd1, 1'b0, 8'd5, 1'b0, 1'b0);
        check("R12 disabled ignores entries", 32'h0040_0ABC, 1'b0, 12'h000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_basic();
        t_sizes();
        t_perm();
        t_multi();
        t_regions();
        t_disabled();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule